// File: doc/BRIEF.md
# Paged Program Counter

This block holds the instruction fetch address of a small accumulator machine. The address is 11 bits wide, but the data path is only 8 bits wide. Software can reach the lower 8 bits of the counter directly. It can either load them with a value or add an offset to them, which is how computed jump tables are built. The remaining address bits come from a separate page latch that software writes ahead of time. That latch has no effect on the counter until a low-byte write or an absolute jump takes effect. Only then are its bits copied into the upper part of the counter.

The counter steps by one instruction word per cycle and wraps at the top of the address space. A stall holds it in place. The instruction that writes the low byte runs while the counter already points one word past it. An added offset of 0 therefore lands on the next instruction. An absolute jump takes the lower 9 target bits from the instruction and the top 2 bits from the upper end of the latch. Any redirect (a low-byte write or a jump) discards the instruction already fetched, and the block signals this with a one-cycle flush.

A small sequencing machine tracks the cycle kind:
- ST_SEQ: counting normally.
- ST_HOLD: stalled.
- ST_FLUSH: the cycle after a redirect.

Every state moves to ST_FLUSH on a redirect, to ST_HOLD on a stall without a redirect, and to ST_SEQ otherwise. The flush output is high exactly in ST_FLUSH.

Top module: `paged_pc`

## Requirements
- R1: While reset is low, fetch_addr is 0, flush is 0 and the page latch is 0. The first low-byte load after reset uses page 0.
- R2: With no stall, low-byte write or jump, fetch_addr rises by 1 on each clock edge and wraps from 2047 to 0.
- R3: A stall without a redirect keeps fetch_addr unchanged and keeps flush low.
- R4: A low-byte write with lo_add=0 sets fetch_addr to {page latch, lo_wdata}.
- R5: A low-byte write with lo_add=1 sets fetch_addr to {page latch, (fetch_addr[7:0] + lo_wdata) mod 256}. An offset of 0 yields the word right after the writing instruction. A carry out of the low byte never reaches the upper bits.
- R6: Writing the page latch alone does not alter the counting sequence of fetch_addr.
- R7: A jump sets fetch_addr to {latch[2:1], jmp_target[8:0]}.
- R8: A redirect in the same cycle as a latch write uses the latch value held before that cycle. The new latch value applies to later redirects.
- R9: flush is 1 in the cycle right after any low-byte write or jump, and 0 after any other cycle.
- R10: lo_rdata always equals fetch_addr[7:0].
- R11: A jump takes priority over a same-cycle low-byte write. A redirect takes priority over a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Hold the counter this cycle |
| lo_we | input | 1 | Low-byte write strobe |
| lo_add | input | 1 | 1: add lo_wdata to low byte, 0: load it |
| lo_wdata | input | 8 | Low-byte data or offset |
| hi_we | input | 1 | Page latch write strobe |
| hi_wdata | input | 3 | Page latch data |
| jmp_en | input | 1 | Absolute jump strobe |
| jmp_target | input | 9 | Jump target bits from the instruction |
| fetch_addr | output | 11 | Current fetch address |
| lo_rdata | output | 8 | Readable low byte of the counter |
| flush | output | 1 | Discard the already-fetched instruction |

## Verification
The main function is exercised in four ways:
- **Low-byte loads under several page values.** These separate the counter's use of the latch from its use of the written data.
- **Offset adds of 0, a small value and a value that overflows the byte.** These distinguish "point past the writer" from "point at the writer", and expose any carry that leaks into the page bits.
- **Jumps with differing latch contents, combined with latch writes, low writes and stalls in the same cycle.** These pin down old-versus-new latch use and the priority order.
- **Plain counting across the top of the address space.** This checks the wrap.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

    typedef enum logic [1:0] {
        ST_SEQ   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_FLUSH = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_INC  = 2'd0,
        SRC_HOLD = 2'd1,
        SRC_LOW  = 2'd2,
        SRC_JMP  = 2'd3
    } pc_src_e;

endpackage

// File: rtl/ppc_page_latch.sv
module ppc_page_latch #(
    parameter int HI_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [HI_W-1:0] wdata,
    output logic [HI_W-1:0] q
);

    // Written by software; consumed only by redirects in later cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/ppc_seq_ctl.sv
module ppc_seq_ctl
    import ppc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    stall,
    input  logic    lo_we,
    input  logic    jmp_en,
    output pc_src_e src,
    output logic    flush
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       redirect;

    assign redirect = lo_we | jmp_en;

    // Next-state selection.
    always_comb begin
        state_d = ST_SEQ;
        unique case (state_q)
            ST_SEQ, ST_HOLD, ST_FLUSH: begin
                if (redirect) begin
                    state_d = ST_FLUSH;
                end else if (stall) begin
                    state_d = ST_HOLD;
                end else begin
                    state_d = ST_SEQ;
                end
            end
            default: state_d = ST_SEQ;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEQ;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs: flush from the state, source selection from this cycle's
    // strobes in priority order jump > low write > stall > increment.
    always_comb begin
        flush = 1'b0;
        unique case (state_q)
            ST_FLUSH: flush = 1'b1;
            ST_SEQ:   flush = 1'b0;
            ST_HOLD:  flush = 1'b0;
            default:  flush = 1'b0;
        endcase

        if (jmp_en) begin
            src = SRC_JMP;
        end else if (lo_we) begin
            src = SRC_LOW;
        end else if (stall) begin
            src = SRC_HOLD;
        end else begin
            src = SRC_INC;
        end
    end

endmodule

// File: rtl/ppc_next_pc.sv
module ppc_next_pc
    import ppc_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int JT_W   = 9,
    parameter int HI_W   = ADDR_W - DATA_W
) (
    input  pc_src_e           src,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [HI_W-1:0]   hi_q,
    input  logic              lo_add,
    input  logic [DATA_W-1:0] lo_wdata,
    input  logic [JT_W-1:0]   jmp_target,
    output logic [ADDR_W-1:0] nxt_pc
);

    localparam int UJ_W = ADDR_W - JT_W;

    logic [DATA_W-1:0] low_sum;
    logic [DATA_W-1:0] low_new;
    logic [ADDR_W-1:0] jmp_pc;

    // Carry out of the low byte is dropped: the page is not advanced.
    assign low_sum = cur_pc[DATA_W-1:0] + lo_wdata;
    assign low_new = lo_add ? low_sum : lo_wdata;

    generate
        if (UJ_W == 0) begin : g_full_jump
            assign jmp_pc = jmp_target;
        end else begin : g_paged_jump
            assign jmp_pc = {hi_q[HI_W-1 -: UJ_W], jmp_target};
        end
    endgenerate

    always_comb begin
        nxt_pc = cur_pc;
        unique case (src)
            SRC_INC:  nxt_pc = cur_pc + ADDR_W'(1);
            SRC_HOLD: nxt_pc = cur_pc;
            SRC_LOW:  nxt_pc = {hi_q, low_new};
            SRC_JMP:  nxt_pc = jmp_pc;
            default:  nxt_pc = cur_pc;
        endcase
    end

endmodule

// File: rtl/paged_pc.sv
module paged_pc
    import ppc_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int JT_W   = 9,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              lo_we,
    input  logic              lo_add,
    input  logic [DATA_W-1:0] lo_wdata,
    input  logic              hi_we,
    input  logic [HI_W-1:0]   hi_wdata,
    input  logic              jmp_en,
    input  logic [JT_W-1:0]   jmp_target,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [DATA_W-1:0] lo_rdata,
    output logic              flush
);

    pc_src_e           src;
    logic [HI_W-1:0]   hi_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;

    ppc_page_latch #(.HI_W(HI_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (hi_we),
        .wdata (hi_wdata),
        .q     (hi_q)
    );

    ppc_seq_ctl u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .stall  (stall),
        .lo_we  (lo_we),
        .jmp_en (jmp_en),
        .src    (src),
        .flush  (flush)
    );

    ppc_next_pc #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .JT_W   (JT_W),
        .HI_W   (HI_W)
    ) u_next (
        .src        (src),
        .cur_pc     (pc_q),
        .hi_q       (hi_q),
        .lo_add     (lo_add),
        .lo_wdata   (lo_wdata),
        .jmp_target (jmp_target),
        .nxt_pc     (pc_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign fetch_addr = pc_q;
    assign lo_rdata   = pc_q[DATA_W-1:0];

endmodule

// File: rtl/paged_pc_chk.sv
module paged_pc_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int JT_W   = 9,
    parameter int HI_W   = ADDR_W - DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              lo_we,
    input logic              jmp_en,
    input logic [JT_W-1:0]   jmp_target,
    input logic [HI_W-1:0]   hi_q,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              flush
);

    a_r1_reset_zero: assert property (@(posedge clk)
        $rose(rst_n) |-> (fetch_addr == '0 && !flush && hi_q == '0));

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !lo_we && !jmp_en) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(1));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !lo_we && !jmp_en) |=> $stable(fetch_addr));

    a_r4_low_page: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_we && !jmp_en) |=> fetch_addr[ADDR_W-1:DATA_W] == $past(hi_q));

    a_r7_jump_low: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_en |=> fetch_addr[JT_W-1:0] == $past(jmp_target));

    a_r9_flush_on: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_we || jmp_en) |=> flush);

    a_r9_flush_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_we && !jmp_en) |=> !flush);

endmodule

bind paged_pc paged_pc_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .JT_W   (JT_W),
    .HI_W   (HI_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .lo_we      (lo_we),
    .jmp_en     (jmp_en),
    .jmp_target (jmp_target),
    .hi_q       (hi_q),
    .fetch_addr (fetch_addr),
    .flush      (flush)
);

// File: tb/paged_pc_tb.sv
module paged_pc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic        lo_we = 1'b0;
    logic        lo_add = 1'b0;
    logic [7:0]  lo_wdata = '0;
    logic        hi_we = 1'b0;
    logic [2:0]  hi_wdata = '0;
    logic        jmp_en = 1'b0;
    logic [8:0]  jmp_target = '0;
    logic [10:0] fetch_addr;
    logic [7:0]  lo_rdata;
    logic        flush;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    paged_pc u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall      (stall),
        .lo_we      (lo_we),
        .lo_add     (lo_add),
        .lo_wdata   (lo_wdata),
        .hi_we      (hi_we),
        .hi_wdata   (hi_wdata),
        .jmp_en     (jmp_en),
        .jmp_target (jmp_target),
        .fetch_addr (fetch_addr),
        .lo_rdata   (lo_rdata),
        .flush      (flush)
    );

    typedef struct packed {
        logic        st;
        logic        lw;
        logic        la;
        logic [7:0]  ld;
        logic        hw;
        logic [2:0]  hd;
        logic        je;
        logic [8:0]  jt;
        logic [10:0] pc;
        logic        fl;
    } vec_t;

    // Each row: inputs for one cycle, then fetch_addr and flush after the edge.
    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,1'b0,8'h00,1'b0,3'd0,1'b0,9'h000,11'd1,   1'b0}, // R2
        '{1'b0,1'b0,1'b0,8'h00,1'b0,3'd0,1'b0,9'h000,11'd2,   1'b0}, // R2
        '{1'b1,1'b0,1'b0,8'h00,1'b0,3'd0,1'b0,9'h000,11'd2,   1'b0}, // R3
        '{1'b0,1'b0,1'b0,8'h00,1'b1,3'd5,1'b0,9'h000,11'd3,   1'b0}, // R6
        '{1'b0,1'b1,1'b0,8'h10,1'b0,3'd0,1'b0,9'h000,11'd1296,1'b1}, // R4
        '{1'b0,1'b0,1'b0,8'h00,1'b0,3'd0,1'b0,9'h000,11'd1297,1'b0}, // R9
        '{1'b0,1'b1,1'b1,8'h00,1'b0,3'd0,1'b0,9'h000,11'd1297,1'b1}, // R5 offset 0
        '{1'b0,1'b1,1'b1,8'h03,1'b0,3'd0,1'b0,9'h000,11'd1300,1'b1}, // R5
        '{1'b0,1'b1,1'b1,8'hF0,1'b1,3'd2,1'b0,9'h000,11'd1284,1'b1}, // R8 R5 carry
        '{1'b0,1'b0,1'b0,8'h00,1'b0,3'd0,1'b0,9'h000,11'd1285,1'b0}, // R6
        '{1'b0,1'b0,1'b0,8'h00,1'b0,3'd0,1'b1,9'h1AB,11'd939, 1'b1}, // R7
        '{1'b0,1'b1,1'b0,8'h00,1'b0,3'd0,1'b1,9'h005,11'd517, 1'b1}, // R11
        '{1'b1,1'b0,1'b0,8'h00,1'b0,3'd0,1'b1,9'h100,11'd768, 1'b1}, // R11
        '{1'b1,1'b0,1'b0,8'h00,1'b0,3'd0,1'b0,9'h000,11'd768, 1'b0}, // R3
        '{1'b0,1'b0,1'b0,8'h00,1'b1,3'd7,1'b0,9'h000,11'd769, 1'b0}, // R6
        '{1'b0,1'b1,1'b0,8'hFF,1'b0,3'd0,1'b0,9'h000,11'd2047,1'b1}, // R4
        '{1'b0,1'b0,1'b0,8'h00,1'b0,3'd0,1'b0,9'h000,11'd0,   1'b0}, // R2 wrap
        '{1'b0,1'b0,1'b0,8'h00,1'b0,3'd0,1'b0,9'h000,11'd1,   1'b0}, // R2
        '{1'b0,1'b0,1'b0,8'h00,1'b0,3'd0,1'b1,9'h1FF,11'd2047,1'b1}, // R7
        '{1'b0,1'b1,1'b1,8'h01,1'b0,3'd0,1'b0,9'h000,11'd1792,1'b1}  // R5 carry
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        stall = 1'b0; lo_we = 1'b0; lo_add = 1'b0; lo_wdata = '0;
        hi_we = 1'b0; hi_wdata = '0; jmp_en = 1'b0; jmp_target = '0;
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        chk("R1 reset addr", int'(fetch_addr), 0);
        chk("R1 reset flush", int'(flush), 0);
        chk("R10 reset low", int'(lo_rdata), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            stall = TBL[i].st; lo_we = TBL[i].lw; lo_add = TBL[i].la;
            lo_wdata = TBL[i].ld; hi_we = TBL[i].hw; hi_wdata = TBL[i].hd;
            jmp_en = TBL[i].je; jmp_target = TBL[i].jt;
            @(posedge clk);
            #1;
            chk($sformatf("R2-chain row %0d addr (R4 R5 R7 R8 R11)", i), int'(fetch_addr), int'(TBL[i].pc));
            chk($sformatf("R9 row %0d flush", i), int'(flush), int'(TBL[i].fl));
            chk($sformatf("R10 row %0d low", i), int'(lo_rdata), int'(TBL[i].pc[7:0]));
            @(negedge clk);
        end

        // R1: mid-run reset clears counter and latch (latch holds 7 here).
        idle_inputs();
        rst_n = 1'b0;
        #1;
        chk("R1 async clear addr", int'(fetch_addr), 0);
        chk("R1 async clear flush", int'(flush), 0);
        @(negedge clk);
        rst_n = 1'b1;
        lo_we = 1'b1; lo_wdata = 8'h33;
        @(posedge clk);
        #1;
        chk("R1 latch cleared", int'(fetch_addr), 51);
        @(negedge clk);
        idle_inputs();
        @(posedge clk);
        #1;
        chk("R9 flush drops", int'(flush), 0);
        chk("R2 step after load", int'(fetch_addr), 52);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule